// File: doc/BRIEF.md
# Packed SIMD Minimum/Maximum Execution Slice

This block is one execution slice of a vector unit. It decodes a 32-bit instruction word and returns the per-lane minimum or maximum of two 128-bit operands. The second operand is either a second vector source or a 5-bit immediate. The immediate is widened to the lane size and copied into every lane.

Lanes can be 8, 16, 32 or 64 bits wide, so one result holds 16, 8, 4 or 2 lanes. Lane 0 occupies the least significant bits. Comparison is either two's-complement or unsigned magnitude. All lanes are computed in parallel.

The upstream stage supplies the operand values, already read from the register file, together with a strobe. One clock later the slice presents the result, the destination register index and a valid flag. If the word is not an encoding this slice accepts, it raises an illegal-instruction flag instead of the valid flag.

Top module: `simd_minmax_unit`

## Requirements
- R1: A word with bits [31:20] = 12'h707 and bit 19 = 0 is a register-register operation. Each lane of `src_a` is compared with the same lane of `src_b`.
- R2: Function bits [16:15] give the lane width: 00 = 8, 01 = 16, 10 = 32 and 11 = 64 bits. Lane i occupies bits [i*W +: W].
- R3: Function bit 17 selects the operation. 1 returns the smaller operand of each lane and 0 returns the larger one.
- R4: Function bit 18 selects the comparison. 0 compares lanes as two's-complement numbers and 1 compares them as unsigned magnitudes.
- R5: A word with bits [31:20] = 12'h729 and bit 19 = 0 is an immediate operation. It compares each lane of `src_a` with bits [14:10]. For signed comparison (bit 18 = 0) those 5 bits are sign-extended to the lane width.
- R6: For unsigned immediate operations (bit 18 = 1), the 5-bit immediate is zero-extended to the lane width.
- R7: A strobed word is illegal if bits [31:20] match neither prefix or bit 19 is set. One clock later `out_illegal` is 1 and `out_valid` is 0.
- R8: For a legal strobed word, `out_valid` is 1 one clock after the strobe. In that same cycle `out_result` holds the lane results and `out_dst` holds instruction bits [4:0].
- R9: The reset is synchronous and active low. It clears `out_valid`, `out_illegal`, `out_result` and `out_dst`.
- R10: `out_result` and `out_dst` keep their values after any cycle with no strobe or with an illegal strobe. `out_valid` is 0 in the cycle that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Strobe: the instruction and operands are present |
| instr | input | 32 | Instruction word |
| src_a | input | 128 | First vector operand |
| src_b | input | 128 | Second vector operand (unused by immediate forms) |
| out_valid | output | 1 | Registered result is valid |
| out_illegal | output | 1 | The strobed word was not a recognised encoding |
| out_dst | output | 5 | Destination register index |
| out_result | output | 128 | Per-lane minimum or maximum |

## Verification
The clocked assertions take two things for granted. `in_valid` and `instr` must be known values at every rising edge, and reset must be held low for at least one edge before the first strobe. The hold check also assumes that the result register changes only on an accepted strobe.

The bench drives every input on the falling clock edge and holds reset for several cycles at the start. After a mid-run reset it deasserts `in_valid` before releasing reset. This keeps the stimulus inside those assumptions.

The per-lane assertions assume the width and signedness decode is stable during a cycle. Because the bench only changes inputs away from the sampling edge, this holds.

// File: rtl/simd_mm_pkg.sv
// Package: shared encodings and the decoded-operation record for the
// min/max slice. Assumes the 17-bit opcode prefix layout described in
// the brief (12-bit major prefix, then the 5-bit function field).
package simd_mm_pkg;

    localparam logic [11:0] PFX_REG_REG = 12'h707;
    localparam logic [11:0] PFX_IMM     = 12'h729;
    localparam int          NUM_WIDTHS  = 4;

    typedef enum logic [1:0] {
        LW_8  = 2'b00,
        LW_16 = 2'b01,
        LW_32 = 2'b10,
        LW_64 = 2'b11
    } lane_w_e;

    typedef struct packed {
        logic       legal;
        logic       use_imm;
        lane_w_e    width;
        logic       take_min;
        logic       unsigned_cmp;
        logic [4:0] dst;
        logic [4:0] imm5;
    } mm_op_t;

endpackage

// File: rtl/mm_decode.sv
// Module: mm_decode
// Purely combinational decode of the instruction word into a mm_op_t.
// Assumes the caller qualifies the result with its own strobe; source
// register index bits [9:5] are consumed upstream and ignored here.
module mm_decode
    import simd_mm_pkg::*;
(
    input  logic [31:0] instr,
    output mm_op_t      op
);

    logic [11:0] prefix;
    logic [4:0]  func;
    logic        is_rr;
    logic        is_imm;
    logic        unused_src_idx;

    assign prefix         = instr[31:20];
    assign func           = instr[19:15];
    assign unused_src_idx = ^instr[9:5];

    // Prefix match for the two accepted instruction classes.
    always_comb begin
        is_rr  = (prefix == PFX_REG_REG);
        is_imm = (prefix == PFX_IMM);
    end

    // Field extraction; function bit 4 must be clear for a legal word.
    always_comb begin
        op.legal        = (is_rr || is_imm) && !func[4];
        op.use_imm      = is_imm;
        op.width        = lane_w_e'(func[1:0]);
        op.take_min     = func[2];
        op.unsigned_cmp = func[3];
        op.dst          = instr[4:0];
        op.imm5         = instr[14:10];
    end

endmodule

// File: rtl/mm_operand_sel.sv
// Module: mm_operand_sel
// Chooses the second comparison operand: either the second vector source
// or the 5-bit immediate extended to the lane width and broadcast to all
// lanes. Assumes VLEN is a multiple of 64.
module mm_operand_sel
    import simd_mm_pkg::*;
#(
    parameter int VLEN = 128
) (
    input  logic [VLEN-1:0] src_b,
    input  logic            use_imm,
    input  logic            unsigned_cmp,
    input  lane_w_e         width,
    input  logic [4:0]      imm5,
    output logic [VLEN-1:0] opnd_b
);

    logic [VLEN-1:0] bcast [NUM_WIDTHS];

    // One broadcast image per lane width.
    for (genvar g = 0; g < NUM_WIDTHS; g++) begin : g_bc
        localparam int W     = 8 << g;
        localparam int LANES = VLEN / W;
        logic [W-1:0] ext;
        // Sign- or zero-extend the immediate to this lane width.
        always_comb begin
            ext = {{(W-5){!unsigned_cmp && imm5[4]}}, imm5};
        end
        // Replicate the extended value into every lane.
        always_comb begin
            bcast[g] = {LANES{ext}};
        end
    end

    // Pick register operand or the broadcast for the decoded width.
    always_comb begin
        opnd_b = use_imm ? bcast[width] : src_b;
    end

endmodule

// File: rtl/mm_lane_array.sv
// Module: mm_lane_array
// All lanes of one fixed width: each lane returns the smaller or larger
// of its two operands. Signed order is obtained by inverting the sign bit
// and comparing unsigned. Assumes LANE_W >= 8 and divides VLEN.
module mm_lane_array #(
    parameter int VLEN   = 128,
    parameter int LANE_W = 8
) (
    input  logic [VLEN-1:0] opnd_a,
    input  logic [VLEN-1:0] opnd_b,
    input  logic            take_min,
    input  logic            unsigned_cmp,
    output logic [VLEN-1:0] res
);

    localparam int LANES = VLEN / LANE_W;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [LANE_W-1:0] la, lb, lr;
        logic [LANE_W-1:0] ka, kb, kr;
        logic              a_lt_b;

        // Slice operands and build order-preserving unsigned keys.
        always_comb begin
            la     = opnd_a[i*LANE_W +: LANE_W];
            lb     = opnd_b[i*LANE_W +: LANE_W];
            ka     = {la[LANE_W-1] ^ !unsigned_cmp, la[LANE_W-2:0]};
            kb     = {lb[LANE_W-1] ^ !unsigned_cmp, lb[LANE_W-2:0]};
            a_lt_b = ka < kb;
        end

        // Select the lane winner for min or max.
        always_comb begin
            if (take_min) lr = a_lt_b ? la : lb;
            else          lr = a_lt_b ? lb : la;
            res[i*LANE_W +: LANE_W] = lr;
        end

        // Key of the selected value, used only by the lane check.
        always_comb begin
            kr = {lr[LANE_W-1] ^ !unsigned_cmp, lr[LANE_W-2:0]};
        end

        // The winner must bound both operands in the requested order.
        always_comb begin
            AST_LANE_ORDER: assert (take_min ? (kr <= ka && kr <= kb)
                                             : (kr >= ka && kr >= kb)); // R3
        end
    end

endmodule

// File: rtl/simd_minmax_unit.sv
// Module: simd_minmax_unit (top)
// Decodes one min/max instruction, computes every lane width in parallel,
// selects the decoded width and registers result, destination and flags
// one clock after the strobe. Assumes operands arrive with the strobe.
module simd_minmax_unit
    import simd_mm_pkg::*;
#(
    parameter int VLEN = 128
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [31:0]     instr,
    input  logic [VLEN-1:0] src_a,
    input  logic [VLEN-1:0] src_b,
    output logic            out_valid,
    output logic            out_illegal,
    output logic [4:0]      out_dst,
    output logic [VLEN-1:0] out_result
);

    mm_op_t          op;
    logic [VLEN-1:0] opnd_b;
    logic [VLEN-1:0] wres [NUM_WIDTHS];
    logic [VLEN-1:0] sel_res;
    logic            accept;

    mm_decode u_decode (
        .instr (instr),
        .op    (op)
    );

    mm_operand_sel #(.VLEN(VLEN)) u_opsel (
        .src_b        (src_b),
        .use_imm      (op.use_imm),
        .unsigned_cmp (op.unsigned_cmp),
        .width        (op.width),
        .imm5         (op.imm5),
        .opnd_b       (opnd_b)
    );

    for (genvar g = 0; g < NUM_WIDTHS; g++) begin : g_width
        mm_lane_array #(.VLEN(VLEN), .LANE_W(8 << g)) u_lanes (
            .opnd_a       (src_a),
            .opnd_b       (opnd_b),
            .take_min     (op.take_min),
            .unsigned_cmp (op.unsigned_cmp),
            .res          (wres[g])
        );
    end

    // Pick the lane-array output for the decoded width.
    always_comb begin
        sel_res = wres[op.width];
        accept  = in_valid && op.legal;
    end

    // Status flags: valid for legal strobes, illegal for the others.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_illegal <= 1'b0;
        end else begin
            out_valid   <= accept;
            out_illegal <= in_valid && !op.legal;
        end
    end

    // Result and destination load only on an accepted instruction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_result <= '0;
            out_dst    <= '0;
        end else if (accept) begin
            out_result <= sel_res;
            out_dst    <= op.dst;
        end
    end

    AST_VALID_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid)); // R8
    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_valid && out_illegal)); // R7
    AST_DST_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_dst == $past(instr[4:0]))); // R8
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(in_valid)) |-> ($stable(out_result) && $stable(out_dst))); // R10

endmodule

// File: tb/simd_minmax_unit_bench.sv
module simd_minmax_unit_bench;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [31:0]  instr = '0;
    logic [127:0] src_a = '0;
    logic [127:0] src_b = '0;
    logic         out_valid, out_illegal;
    logic [4:0]   out_dst;
    logic [127:0] out_result;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    simd_minmax_unit u_simd_minmax_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
        .src_a(src_a), .src_b(src_b), .out_valid(out_valid),
        .out_illegal(out_illegal), .out_dst(out_dst), .out_result(out_result)
    );

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input bit imm, input logic [4:0] fn,
                                       input logic [4:0] f2, input logic [4:0] dst);
        return {(imm ? 12'h729 : 12'h707), fn, f2, 5'd3, dst};
    endfunction

    // Behavioural reference built from the requirements.
    function automatic logic [127:0] ref_calc(input logic [31:0] ins,
                                              input logic [127:0] a, input logic [127:0] b);
        logic [127:0] r = '0;
        bit  imm  = (ins[31:20] == 12'h729);
        int  w    = 8 << ins[16:15];
        bit  mn   = ins[17];
        bit  uns  = ins[18];
        longint unsigned mask = (w == 64) ? '1 : ((64'd1 << w) - 1);
        for (int i = 0; i < 128 / w; i++) begin
            longint unsigned ua, ub, pick;
            longint sa, sb;
            bit lt;
            ua = 64'(a >> (i*w)) & mask;
            if (imm) begin
                ub = uns ? 64'(ins[14:10])
                         : (64'(longint'({{59{ins[14]}}, ins[14:10]})) & mask);
            end else begin
                ub = 64'(b >> (i*w)) & mask;
            end
            sa = longint'(ua << (64-w)) >>> (64-w);
            sb = longint'(ub << (64-w)) >>> (64-w);
            lt = uns ? (ua < ub) : (sa < sb);
            pick = mn ? (lt ? ua : ub) : (lt ? ub : ua);
            r |= 128'(pick) << (i*w);
        end
        return r;
    endfunction

    // Drive one strobe at the falling edge; sample one clock later.
    task automatic issue(input logic [31:0] ins, input logic [127:0] a, input logic [127:0] b);
        instr = ins; src_a = a; src_b = b; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic run_exec(input string tag, input logic [31:0] ins,
                            input logic [127:0] a, input logic [127:0] b);
        logic [127:0] exp = ref_calc(ins, a, b);
        issue(ins, a, b);
        chk({tag, " valid R8"}, 128'(out_valid), 128'(1'b1));
        chk({tag, " dst R8"}, 128'(out_dst), 128'(ins[4:0]));
        chk(tag, out_result, exp);
    endtask

    task automatic t_reset_state();
        chk("R9 reset valid", 128'(out_valid), 128'(0));
        chk("R9 reset illegal", 128'(out_illegal), 128'(0));
        chk("R9 reset result", out_result, 128'(0));
        chk("R9 reset dst", 128'(out_dst), 128'(0));
    endtask

    task automatic t_reg_reg_all();
        logic [127:0] pats [6];
        pats[0] = {16{8'h80}};
        pats[1] = {16{8'h7f}};
        pats[2] = {2{64'h8000_0000_0000_0000}};
        pats[3] = {2{64'h7fff_ffff_ffff_ffff}};
        pats[4] = '1;
        pats[5] = {$urandom, $urandom, $urandom, $urandom};
        for (int f = 0; f < 16; f++) begin
            for (int p = 0; p < 6; p++) begin
                run_exec("R1 R2 R3 R4 reg-reg", mk(1'b0, 5'(f), 5'd2, 5'(f)),
                         pats[p], pats[(p + 1) % 6]);
                run_exec("R1 R2 R3 R4 reg-reg rnd", mk(1'b0, 5'(f), 5'd7, 5'(31 - f)),
                         {$urandom, $urandom, $urandom, $urandom},
                         {$urandom, $urandom, $urandom, $urandom});
            end
        end
    endtask

    task automatic t_imm_all();
        logic [4:0] imms [5] = '{5'b10000, 5'b11111, 5'b00000, 5'b01111, 5'b11111};
        logic [127:0] a_pats [3];
        a_pats[0] = {8{16'h8000}};
        a_pats[1] = {4{32'h7fff_ffff}};
        a_pats[2] = 128'h00ff_fff0_0010_0001_ffee_0005_8001_7ffe;
        for (int f = 0; f < 16; f++) begin
            for (int k = 0; k < 5; k++) begin
                for (int p = 0; p < 3; p++) begin
                    run_exec(f[3] ? "R5 R6 imm unsigned zero-ext" : "R5 imm signed sign-ext",
                             mk(1'b1, 5'(f), imms[k], 5'd9), a_pats[p], '1);
                end
            end
        end
    endtask

    task automatic t_known_values();
        // 8-bit lane 0 = 0x80 vs 0x7f: signed min picks 0x80, unsigned min picks 0x7f.
        issue(mk(1'b0, 5'b00100, 5'd0, 5'd1), 128'h80, 128'h7f);
        chk("R4 signed min 8b", out_result, 128'h80);
        issue(mk(1'b0, 5'b01100, 5'd0, 5'd1), 128'h80, 128'h7f);
        chk("R4 unsigned min 8b", out_result, 128'h7f);
        issue(mk(1'b0, 5'b00000, 5'd0, 5'd1), 128'h80, 128'h7f);
        chk("R3 signed max 8b", out_result, 128'h7f);
        // 16-bit lanes, lane 1 holds the larger value: lane 0 is LSB.
        issue(mk(1'b0, 5'b01001, 5'd0, 5'd1), 128'h0005_0001, 128'h0002_0003);
        chk("R2 lane order 16b", out_result, 128'h0005_0003);
        // Immediate -1 signed max on 64-bit lanes of -5 gives all ones.
        issue(mk(1'b1, 5'b00011, 5'b11111, 5'd1), {2{64'hffff_ffff_ffff_fffb}}, '0);
        chk("R5 imm -1 max 64b", out_result, '1);
        // Immediate 31 unsigned min on lanes of 0xff gives 0x1f.
        issue(mk(1'b1, 5'b01100, 5'b11111, 5'd1), '1, '0);
        chk("R6 imm 31 umin 8b", out_result, {16{8'h1f}});
    endtask

    task automatic t_illegal();
        logic [127:0] held;
        run_exec("R1 prime", mk(1'b0, 5'd1, 5'd0, 5'd17), 128'h1234, 128'h99);
        held = out_result;
        issue({12'h708, 5'd0, 15'h0}, '1, '1);
        chk("R7 bad prefix illegal", 128'(out_illegal), 128'(1));
        chk("R7 bad prefix valid", 128'(out_valid), 128'(0));
        chk("R10 bad prefix result held", out_result, held);
        issue(mk(1'b0, 5'b10000, 5'd0, 5'd4), '1, '1);
        chk("R7 func bit4 illegal", 128'(out_illegal), 128'(1));
        chk("R7 func bit4 valid", 128'(out_valid), 128'(0));
        chk("R10 func bit4 dst held", 128'(out_dst), 128'(17));
        issue(mk(1'b1, 5'b11011, 5'd5, 5'd4), '1, '1);
        chk("R7 imm bit4 illegal", 128'(out_illegal), 128'(1));
        @(negedge clk);
        chk("R7 illegal clears", 128'(out_illegal), 128'(0));
    endtask

    task automatic t_idle_hold();
        logic [127:0] held = out_result;
        instr = mk(1'b0, 5'd0, 5'd0, 5'd30); src_a = '1; src_b = '1; in_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R10 idle valid", 128'(out_valid), 128'(0));
        chk("R10 idle result", out_result, held);
        chk("R10 idle dst", 128'(out_dst), 128'(17));
    endtask

    task automatic t_back_to_back();
        logic [31:0] i1 = mk(1'b0, 5'b00010, 5'd0, 5'd11);
        logic [31:0] i2 = mk(1'b1, 5'b01110, 5'd9, 5'd12);
        logic [127:0] a1 = {$urandom, $urandom, $urandom, $urandom};
        logic [127:0] a2 = {$urandom, $urandom, $urandom, $urandom};
        instr = i1; src_a = a1; src_b = a2; in_valid = 1'b1;
        #5;
        chk("R8 no output before edge", 128'(out_valid), 128'(0));
        @(negedge clk);
        chk("R8 first result", out_result, ref_calc(i1, a1, a2));
        chk("R8 first dst", 128'(out_dst), 128'(11));
        instr = i2; src_a = a2;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R8 second result", out_result, ref_calc(i2, a2, '0));
        chk("R8 second dst", 128'(out_dst), 128'(12));
        chk("R8 second valid", 128'(out_valid), 128'(1));
    endtask

    task automatic t_mid_reset();
        run_exec("R1 before reset", mk(1'b0, 5'd3, 5'd0, 5'd21), 128'h5, 128'h6);
        instr = {12'h000, 20'h0}; in_valid = 1'b1;
        rst_n = 1'b0;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
    endtask

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_known_values();
        t_reg_reg_all();
        t_imm_all();
        t_illegal();
        t_idle_hold();
        t_back_to_back();
        t_mid_reset();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule